// File: doc/BRIEF.md
# Planar Graphics Write/Read Datapath

This block sits between a byte-wide CPU port and four video memory bit planes. Any CPU read captures the addressed byte of every plane into four plane latches. The CPU then gets back either one selected plane or a per-pixel colour-match byte. A CPU write turns one CPU byte into four plane bytes and a 4-bit plane write enable. Four write modes set how that happens: rotate with per-plane constant substitution, latch copy, colour splat, and masked colour fill. In rotate and splat modes the result is combined with the latches through a logic function and a per-bit mask.

Configuration goes through an index/data strobe into nine small registers. Memory addressing and the memory itself live outside the block. The memory read data arrives as one 32-bit vector, and the write data leaves as one. Plane p occupies bits [8p+7:8p] of each vector. Read data is taken at the clock edge on which `cpu_rd` is high. Write data and enables are combinational from `cpu_wr`, `cpu_wdata`, the registers and the latches, so the memory can capture them on the same edge.

Top module: `gfx_plane_datapath`

## Requirements
- R1: After reset every configuration register reads as zero, except the bit mask, which is 0xFF. As a result, a write at reset puts the unmodified CPU byte on all four planes with no plane enabled, and a read returns plane 0.
- R2: A clock edge with `cpu_rd` high loads all four plane latches from `mem_rdata`. The latches hold their value at every other edge.
- R3: In read mode 0 (mode register index 5 bit 3 clear), `cpu_rdata` is the latch of the plane given by the read plane register (index 4, bits 1:0).
- R4: In read mode 1, bit i of `cpu_rdata` is 1 when the 4-bit pixel formed by bit i of each latch equals the compare colour (index 2, bits 3:0). Only planes whose bit is set in the compare-include register (index 6) take part in the comparison.
- R5: In write mode 0 (index 5 bits 1:0 = 0), the CPU byte is rotated right by the rotate count (index 3, bits 2:0). Then, for each plane whose bit is set in the constant-enable register (index 1), the data is replaced by that plane's bit of the constant colour (index 0) copied to all 8 bits.
- R6: In write modes 0 and 2, the logic function (index 3, bits 4:3) combines the data with the plane latch: 0 passes the data through, 1 ANDs, 2 ORs and 3 XORs.
- R7: In write modes 0 and 2, the logic function is applied first, then the bit mask (index 7). Each set mask bit passes the computed bit, and each clear mask bit writes the latch bit back.
- R8: In write mode 1, each plane receives its latch unchanged, whatever the CPU data, function and mask are.
- R9: In write mode 2, bit n of the CPU byte is copied across all 8 bits of plane n before the function and the mask are applied.
- R10: In write mode 3, the rotated CPU byte ANDed with the bit mask is a per-bit selector. A set bit takes the plane's constant colour bit and a clear bit takes the latch bit. The logic function is bypassed.
- R11: `mem_we` equals the plane write mask (index 8, bits 3:0) while `cpu_wr` is high, and is zero otherwise.
- R12: A configuration write to an index from 9 to 15 changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration register write strobe |
| cfg_idx | input | 4 | Configuration register index |
| cfg_wdata | input | 8 | Configuration write data |
| cpu_rd | input | 1 | CPU read: loads the plane latches |
| mem_rdata | input | 32 | Addressed byte of each plane, plane p at [8p+7:8p] |
| cpu_rdata | output | 8 | Read result from the latches |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_wdata | input | 8 | CPU write byte |
| mem_wdata | output | 32 | Byte to write to each plane, plane p at [8p+7:8p] |
| mem_we | output | 4 | Per-plane write enable |

## Verification
The embedded assertions check, on every cycle, that the latches load only on a read and otherwise hold. They also check that write enables stay inside the plane mask and are silent without a write, that mode 1 copies the latches, and that bits with a clear mask bit in modes 0 and 2 always carry the latch value. The assertions cannot show that the rotate amount, the constant substitution, the logic function, the splat and fill selection, or the colour-compare result are numerically right. The bench's sweeps compare those against a bit-by-bit model across every mode, function and rotate count, and across every compare colour and include mask.

// File: rtl/gfx_dp_pkg.sv
package gfx_dp_pkg;
  parameter int unsigned NPL   = 4;
  parameter int unsigned DW    = 8;
  parameter int unsigned IDX_W = 4;
  localparam int unsigned RW   = $clog2(DW);
  localparam int unsigned MW   = $clog2(NPL);
  localparam int unsigned BUS_W = NPL * DW;

  typedef enum logic [1:0] {
    WM_ROT   = 2'd0,
    WM_COPY  = 2'd1,
    WM_SPLAT = 2'd2,
    WM_FILL  = 2'd3
  } wmode_e;

  typedef enum logic [1:0] {
    FN_PASS = 2'd0,
    FN_AND  = 2'd1,
    FN_OR   = 2'd2,
    FN_XOR  = 2'd3
  } func_e;

  typedef struct packed {
    logic [NPL-1:0] konst;
    logic [NPL-1:0] konst_en;
    logic [NPL-1:0] cmp_col;
    logic [NPL-1:0] cmp_inc;
    logic [NPL-1:0] pmask;
    logic [RW-1:0]  rot;
    logic [1:0]     fn;
    logic [MW-1:0]  rsel;
    logic [1:0]     wmode;
    logic           rmode;
    logic [DW-1:0]  bmask;
  } cfg_t;

  function automatic logic [DW-1:0] rot_right(input logic [DW-1:0] d, input logic [RW-1:0] n);
    logic [2*DW-1:0] t;
    t = {d, d} >> n;
    return t[DW-1:0];
  endfunction

  function automatic logic [DW-1:0] apply_fn(input logic [DW-1:0] d, input logic [DW-1:0] l,
                                             input logic [1:0] fn);
    case (func_e'(fn))
      FN_AND:  return d & l;
      FN_OR:   return d | l;
      FN_XOR:  return d ^ l;
      default: return d;
    endcase
  endfunction

  function automatic logic [DW-1:0] mask_merge(input logic [DW-1:0] d, input logic [DW-1:0] l,
                                               input logic [DW-1:0] m);
    return (d & m) | (l & ~m);
  endfunction
endpackage

// File: rtl/gfx_dp_regs.sv
module gfx_dp_regs
  import gfx_dp_pkg::*;
#(
  parameter logic [DW-1:0] BMASK_RST = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [IDX_W-1:0] cfg_idx,
  input  logic [DW-1:0]    cfg_wdata,
  output cfg_t             cfg
);
  localparam logic [IDX_W-1:0] IX_KONST = 0;
  localparam logic [IDX_W-1:0] IX_KEN   = 1;
  localparam logic [IDX_W-1:0] IX_CCOL  = 2;
  localparam logic [IDX_W-1:0] IX_ROTFN = 3;
  localparam logic [IDX_W-1:0] IX_RSEL  = 4;
  localparam logic [IDX_W-1:0] IX_MODE  = 5;
  localparam logic [IDX_W-1:0] IX_CINC  = 6;
  localparam logic [IDX_W-1:0] IX_BMASK = 7;
  localparam logic [IDX_W-1:0] IX_PMASK = 8;

  cfg_t cfg_q;
  wire  idx_known = (cfg_idx <= IX_PMASK);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q       <= '0;
      cfg_q.bmask <= BMASK_RST;
    end else if (cfg_we) begin
      case (cfg_idx)
        IX_KONST: cfg_q.konst    <= cfg_wdata[NPL-1:0];
        IX_KEN:   cfg_q.konst_en <= cfg_wdata[NPL-1:0];
        IX_CCOL:  cfg_q.cmp_col  <= cfg_wdata[NPL-1:0];
        IX_ROTFN: begin
          cfg_q.rot <= cfg_wdata[RW-1:0];
          cfg_q.fn  <= cfg_wdata[RW+1:RW];
        end
        IX_RSEL:  cfg_q.rsel     <= cfg_wdata[MW-1:0];
        IX_MODE:  begin
          cfg_q.wmode <= cfg_wdata[1:0];
          cfg_q.rmode <= cfg_wdata[3];
        end
        IX_CINC:  cfg_q.cmp_inc  <= cfg_wdata[NPL-1:0];
        IX_BMASK: cfg_q.bmask    <= cfg_wdata;
        IX_PMASK: cfg_q.pmask    <= cfg_wdata[NPL-1:0];
        default:  ;
      endcase
    end
  end

  assign cfg = cfg_q;

  AST_UNKNOWN_IDX_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !idx_known) |=> $stable(cfg_q)); // R12
endmodule

// File: rtl/gfx_dp_rd.sv
module gfx_dp_rd
  import gfx_dp_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cpu_rd,
  input  logic [NPL-1:0][DW-1:0]   mem_rdata,
  input  logic [MW-1:0]            rsel,
  input  logic                     rmode,
  input  logic [NPL-1:0]           cmp_col,
  input  logic [NPL-1:0]           cmp_inc,
  output logic [NPL-1:0][DW-1:0]   latch,
  output logic [DW-1:0]            cpu_rdata
);
  logic [NPL-1:0][DW-1:0] lat_q;
  logic [DW-1:0]          match;
  wire                    latch_load = cpu_rd;

  always_ff @(posedge clk) begin
    if (!rst_n)          lat_q <= '0;
    else if (latch_load) lat_q <= mem_rdata;
  end

  for (genvar i = 0; i < DW; i++) begin : g_px
    logic [NPL-1:0] pix;
    for (genvar p = 0; p < NPL; p++) begin : g_pl
      assign pix[p] = lat_q[p][i];
    end
    assign match[i] = (((pix ^ cmp_col) & cmp_inc) == '0);
  end

  assign latch     = lat_q;
  assign cpu_rdata = rmode ? match : lat_q[rsel];

  AST_LATCH_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    latch_load |=> (lat_q == $past(mem_rdata))); // R2
  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !latch_load |=> $stable(lat_q)); // R2
  AST_NO_INCLUDE_ALL_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (rmode && cmp_inc == '0) |-> (cpu_rdata == '1)); // R4
endmodule

// File: rtl/gfx_dp_wr.sv
module gfx_dp_wr
  import gfx_dp_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cpu_wr,
  input  logic [DW-1:0]            cpu_wdata,
  input  logic [NPL-1:0][DW-1:0]   latch,
  input  logic [NPL-1:0]           konst,
  input  logic [NPL-1:0]           konst_en,
  input  logic [NPL-1:0]           pmask,
  input  logic [RW-1:0]            rot,
  input  logic [1:0]               fn,
  input  logic [1:0]               wmode,
  input  logic [DW-1:0]            bmask,
  output logic [NPL-1:0][DW-1:0]   mem_wdata,
  output logic [NPL-1:0]           mem_we
);
  logic [DW-1:0] rotated;
  logic [DW-1:0] fill_sel;
  wire           masked_mode = (wmode == WM_ROT) || (wmode == WM_SPLAT);

  assign rotated  = rot_right(cpu_wdata, rot);
  assign fill_sel = rotated & bmask;

  for (genvar p = 0; p < NPL; p++) begin : g_plane
    logic [DW-1:0] src;
    logic [DW-1:0] fnout;
    always_comb begin
      if (wmode == WM_SPLAT)  src = {DW{cpu_wdata[p]}};
      else if (konst_en[p])   src = {DW{konst[p]}};
      else                    src = rotated;
    end
    assign fnout = apply_fn(src, latch[p], fn);
    always_comb begin
      case (wmode_e'(wmode))
        WM_COPY: mem_wdata[p] = latch[p];
        WM_FILL: mem_wdata[p] = mask_merge({DW{konst[p]}}, latch[p], fill_sel);
        default: mem_wdata[p] = mask_merge(fnout, latch[p], bmask);
      endcase
    end
  end

  assign mem_we = cpu_wr ? pmask : '0;

  AST_WE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_wr |-> (mem_we == '0)); // R11
  AST_WE_IN_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we & ~pmask) == '0); // R11
  AST_COPY_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (wmode == WM_COPY) |-> (mem_wdata == latch)); // R8
  AST_MASK_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    masked_mode |-> (((mem_wdata ^ latch) & ~{NPL{bmask}}) == '0)); // R7
  AST_FILL_NO_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    (wmode == WM_FILL && fill_sel == '0) |-> (mem_wdata == latch)); // R10
endmodule

// File: rtl/gfx_plane_datapath.sv
module gfx_plane_datapath
  import gfx_dp_pkg::*;
#(
  parameter logic [DW-1:0] BMASK_RST = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [IDX_W-1:0] cfg_idx,
  input  logic [DW-1:0]    cfg_wdata,
  input  logic             cpu_rd,
  input  logic [BUS_W-1:0] mem_rdata,
  output logic [DW-1:0]    cpu_rdata,
  input  logic             cpu_wr,
  input  logic [DW-1:0]    cpu_wdata,
  output logic [BUS_W-1:0] mem_wdata,
  output logic [NPL-1:0]   mem_we
);
  cfg_t                   cfg;
  logic [NPL-1:0][DW-1:0] latch;
  logic [NPL-1:0][DW-1:0] rd_bus;
  logic [NPL-1:0][DW-1:0] wr_bus;

  assign rd_bus    = mem_rdata;
  assign mem_wdata = wr_bus;

  gfx_dp_regs #(.BMASK_RST(BMASK_RST)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_wdata(cfg_wdata), .cfg(cfg)
  );

  gfx_dp_rd u_rd (
    .clk(clk), .rst_n(rst_n), .cpu_rd(cpu_rd), .mem_rdata(rd_bus),
    .rsel(cfg.rsel), .rmode(cfg.rmode), .cmp_col(cfg.cmp_col),
    .cmp_inc(cfg.cmp_inc), .latch(latch), .cpu_rdata(cpu_rdata)
  );

  gfx_dp_wr u_wr (
    .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata),
    .latch(latch), .konst(cfg.konst), .konst_en(cfg.konst_en),
    .pmask(cfg.pmask), .rot(cfg.rot), .fn(cfg.fn), .wmode(cfg.wmode),
    .bmask(cfg.bmask), .mem_wdata(wr_bus), .mem_we(mem_we)
  );
endmodule

// File: tb/tb_gfx_plane_datapath.sv
`timescale 1ns/1ps
module tb_gfx_plane_datapath;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_idx = '0;
  logic [7:0]  cfg_wdata = '0;
  logic        cpu_rd = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic [7:0]  cpu_rdata;
  logic        cpu_wr = 1'b0;
  logic [7:0]  cpu_wdata = '0;
  logic [31:0] mem_wdata;
  logic [3:0]  mem_we;

  always #2 clk = ~clk;

  gfx_plane_datapath dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_wdata(cfg_wdata), .cpu_rd(cpu_rd), .mem_rdata(mem_rdata),
    .cpu_rdata(cpu_rdata), .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata),
    .mem_wdata(mem_wdata), .mem_we(mem_we)
  );

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  // bench-side copy of the configuration written so far
  logic [3:0]  m_k = 0, m_ken = 0, m_cc = 0, m_ci = 0, m_pm = 0;
  logic [2:0]  m_rot = 0;
  logic [1:0]  m_fn = 0, m_rs = 0, m_wm = 0;
  logic        m_rm = 0;
  logic [7:0]  m_bm = 8'hFF;
  logic [31:0] m_lat = 0;
  logic [31:0] seed = 32'h1234_5678;

  function automatic logic [31:0] nxt(input logic [31:0] s);
    logic [31:0] x = s;
    x ^= x << 13; x ^= x >> 17; x ^= x << 5;
    return x;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cfg(input logic [3:0] idx, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = idx; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic load(input logic [31:0] pat);
    @(negedge clk);
    cpu_rd = 1'b1; mem_rdata = pat;
    @(negedge clk);
    cpu_rd = 1'b0; mem_rdata = ~pat;
    m_lat = pat;
    #1;
  endtask

  function automatic logic opb(input logic d, input logic l, input logic [1:0] f);
    if (f == 1) return d & l;
    if (f == 2) return d | l;
    if (f == 3) return d ^ l;
    return d;
  endfunction

  function automatic logic [31:0] exp_wr(input logic [7:0] c);
    logic [31:0] r = 0;
    for (int p = 0; p < 4; p++)
      for (int i = 0; i < 8; i++) begin
        logic lb, rb, d;
        lb = m_lat[p*8+i];
        rb = c[(i + m_rot) % 8];
        case (m_wm)
          0: begin d = m_ken[p] ? m_k[p] : rb; r[p*8+i] = m_bm[i] ? opb(d, lb, m_fn) : lb; end
          1: r[p*8+i] = lb;
          2: r[p*8+i] = m_bm[i] ? opb(c[p], lb, m_fn) : lb;
          default: r[p*8+i] = (rb & m_bm[i]) ? m_k[p] : lb;
        endcase
      end
    return r;
  endfunction

  function automatic logic [7:0] exp_rd();
    logic [7:0] r = 0;
    if (!m_rm) return m_lat[m_rs*8 +: 8];
    for (int i = 0; i < 8; i++) begin
      logic ok = 1'b1;
      for (int p = 0; p < 4; p++)
        if (m_ci[p] && (m_lat[p*8+i] != m_cc[p])) ok = 1'b0;
      r[i] = ok;
    end
    return r;
  endfunction

  task automatic wr_chk(input logic [7:0] c, input string tag);
    @(negedge clk);
    cpu_wr = 1'b1; cpu_wdata = c;
    #1;
    chk(tag, mem_wdata, exp_wr(c));
    chk("R11 we", {28'd0, mem_we}, {28'd0, m_pm});
    @(negedge clk);
    cpu_wr = 1'b0;
    #1;
    chk("R11 idle", {28'd0, mem_we}, 32'd0);
  endtask

  initial begin
    #(4 * 190000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state seen at the ports
    load(32'hA1B2_C3D4);
    chk("R1 rd plane0", {24'd0, cpu_rdata}, 32'h0000_00D4);
    wr_chk(8'h5C, "R1 write");

    // R12: unknown indexes change nothing
    for (int ix = 9; ix < 16; ix++) cfg(ix[3:0], 8'hFF);
    wr_chk(8'h93, "R12 ignored");
    load(32'h0F1E_2D3C);
    chk("R12 rd", {24'd0, cpu_rdata}, {24'd0, exp_rd()});

    // R2 R3: read plane select over several patterns
    for (int n = 0; n < 8; n++) begin
      seed = nxt(seed);
      load(seed);
      for (int s = 0; s < 4; s++) begin
        m_rs = s[1:0]; cfg(4, {6'd0, m_rs});
        #1 chk("R3 R2 plane", {24'd0, cpu_rdata}, {24'd0, exp_rd()});
      end
    end

    // R4: colour compare over every colour and include mask
    m_rm = 1; cfg(5, 8'h08);
    for (int n = 0; n < 2; n++) begin
      load(n == 0 ? 32'hF0CC_AA00 : 32'h3C5A_96E1);
      for (int cc = 0; cc < 16; cc++) begin
        m_cc = cc[3:0]; cfg(2, {4'd0, m_cc});
        for (int ci = 0; ci < 16; ci++) begin
          m_ci = ci[3:0]; cfg(6, {4'd0, m_ci});
          #1 chk("R4 compare", {24'd0, cpu_rdata}, {24'd0, exp_rd()});
        end
      end
    end
    m_rm = 0;

    // R5 R6 R7 R8 R9 R10 R11: write sweep
    for (int wm = 0; wm < 4; wm++)
      for (int fn = 0; fn < 4; fn++)
        for (int rt = 0; rt < 8; rt++)
          for (int k = 0; k < 4; k++) begin
            seed = nxt(seed);
            m_wm = wm[1:0]; m_fn = fn[1:0]; m_rot = rt[2:0];
            m_ken = 4'(k * 5); m_k = seed[3:0];
            m_bm = (k == 0) ? 8'hFF : seed[11:4];
            m_pm = seed[15:12];
            cfg(5, {6'd0, m_wm});
            cfg(3, {3'd0, m_fn, m_rot});
            cfg(0, {4'd0, m_k});
            cfg(1, {4'd0, m_ken});
            cfg(7, m_bm);
            cfg(8, {4'd0, m_pm});
            seed = nxt(seed);
            load(seed);
            seed = nxt(seed);
            case (wm)
              0: wr_chk(seed[7:0], "R5 R6 R7 rotate mode");
              1: wr_chk(seed[7:0], "R8 copy mode");
              2: wr_chk(seed[7:0], "R9 R6 R7 splat mode");
              default: wr_chk(seed[7:0], "R10 fill mode");
            endcase
          end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule